// File: doc/BRIEF.md
# Memory-Mapped GPIO Controller with Pin Interrupts

This block is a general-purpose I/O controller reached over an APB slave port. It serves up to four ports of pins. Each port has an output-value register, a direction register that decides which of its pins are driven, and a read-only view of the pin levels as seen after synchronisation. Every pad input passes through two flip-flops before anything inside the block uses it.

Only the first port (port 0) can raise interrupts. For each of its pins, software chooses whether the pin takes part at all, whether it is masked, whether it is level or edge sensitive, and which polarity counts as active. Edge events are held in a latch until software clears them by writing ones to an end-of-interrupt register. Level conditions are never latched. The pending, unmasked conditions can be read back, and their OR drives a single registered interrupt line.

The APB port has no wait states. Reads come from a combinational mux during the access phase. A write takes effect on the clock edge that ends the access phase.

Top module: `apb_gpio_ctrl`

## Requirements
- R1: After reset, every register reads 0, `pad_out` and `pad_oe` are 0, and `irq` is 0.
- R2: For port n (0..NUM_PORTS-1), the output-value register is at byte address 0x0C·n and the direction register is at 0x04+0x0C·n. Both read back what was written. `pad_out[n*PORT_W +: PORT_W]` carries the output value, and `pad_oe` carries the direction, where bit 1 means drive.
- R3: Address 0x50+0x04·n returns port n's pad inputs, delayed by a two-flop synchroniser. Writes to these addresses change nothing.
- R4: Addresses that map to no register read as 0, and writing them changes no register. Examples are 0x08, 0x44, 0x60 and the slots of absent ports.
- R5: When a port 0 pin is in level mode (type bit 0 at 0x38), enabled (bit 1 at 0x30) and unmasked (bit 0 at 0x34), its bit in the status register at 0x40 is 1 exactly while the synchronised pin matches its polarity. Polarity is set at 0x3C, where 1 means high and 0 means low. Level status is not latched, and writes to 0x4C do not affect it.
- R6: When a port 0 pin is in edge mode (type bit 1), an enabled pin latches an event on a rising edge if its polarity bit is 1, or on a falling edge if it is 0. The latched event stays set until a 1 is written to that bit of 0x4C. Bits written as 0 leave their latches unchanged.
- R7: A mask bit of 1 hides its pin from the status register and from `irq`. An edge latched while the pin is masked appears in status once the mask bit is cleared.
- R8: A pin whose enable bit is 0 never shows in status, whatever its input does.
- R9: Rewriting the polarity register never creates an edge event by itself.
- R10: `irq` is the OR of the status bits, registered. It changes one clock after status changes.
- R11: If an end-of-interrupt write clears a pin in the same cycle that a new edge on that pin is detected, the new event stays latched.
- R12: The enable, mask, type and polarity registers read back what was written. The status register is read-only, and writing 0x40 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| pad_in | input | NUM_PORTS*PORT_W | Pad input levels, asynchronous |
| pad_out | output | NUM_PORTS*PORT_W | Pad output values |
| pad_oe | output | NUM_PORTS*PORT_W | Pad output enables |
| irq | output | 1 | Combined interrupt, registered |

## Verification
Two functions can fall in the same clock edge: an end-of-interrupt write and the detection of a new edge on a pin. The bench provokes this by changing a pad one clock before starting an APB write to 0x4C. The write's access phase then ends on the same edge that the synchronised edge reaches the latch. One pin in that write already holds an event and is expected to clear. The other pin's new event is expected to survive. A second case rewrites the polarity while the input is steady and checks that no event appears.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

    localparam int ADDR_W      = 8;
    localparam int DATA_W      = 32;
    localparam int MAX_PORTS   = 4;
    localparam int PORT_STRIDE = 'h0C;
    localparam int EXT_STRIDE  = 'h04;

    localparam logic [ADDR_W-1:0] OUT_BASE  = 8'h00;
    localparam logic [ADDR_W-1:0] DIR_BASE  = 8'h04;
    localparam logic [ADDR_W-1:0] EXT_BASE  = 8'h50;
    localparam logic [ADDR_W-1:0] IEN_ADDR  = 8'h30;
    localparam logic [ADDR_W-1:0] IMSK_ADDR = 8'h34;
    localparam logic [ADDR_W-1:0] ITYP_ADDR = 8'h38;
    localparam logic [ADDR_W-1:0] IPOL_ADDR = 8'h3C;
    localparam logic [ADDR_W-1:0] ISTA_ADDR = 8'h40;
    localparam logic [ADDR_W-1:0] IEOI_ADDR = 8'h4C;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_OUT, SEL_DIR, SEL_EXT,
        SEL_IEN, SEL_IMSK, SEL_ITYP, SEL_IPOL, SEL_ISTA, SEL_IEOI
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e   sel;
        logic [1:0] port;
    } reg_hit_t;

    function automatic reg_hit_t decode_addr(input logic [ADDR_W-1:0] a, input int nports);
        reg_hit_t h;
        h.sel  = SEL_NONE;
        h.port = 2'd0;
        case (a)
            IEN_ADDR:  h.sel = SEL_IEN;
            IMSK_ADDR: h.sel = SEL_IMSK;
            ITYP_ADDR: h.sel = SEL_ITYP;
            IPOL_ADDR: h.sel = SEL_IPOL;
            ISTA_ADDR: h.sel = SEL_ISTA;
            IEOI_ADDR: h.sel = SEL_IEOI;
            default:   h.sel = SEL_NONE;
        endcase
        for (int p = 0; p < MAX_PORTS; p++) begin
            if (p < nports) begin
                if (a == OUT_BASE + ADDR_W'(p * PORT_STRIDE)) begin
                    h.sel = SEL_OUT; h.port = 2'(p);
                end
                if (a == DIR_BASE + ADDR_W'(p * PORT_STRIDE)) begin
                    h.sel = SEL_DIR; h.port = 2'(p);
                end
                if (a == EXT_BASE + ADDR_W'(p * EXT_STRIDE)) begin
                    h.sel = SEL_EXT; h.port = 2'(p);
                end
            end
        end
        return h;
    endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;

    // R3
    sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (q_o == $past(d_i, 2)));

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_ctrl_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din_i,
    input  logic         wr_i,
    input  reg_sel_e     sel_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] en_o,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] kind_o,
    output logic [W-1:0] pol_o,
    output logic [W-1:0] status_o,
    output logic         irq_o
);
    logic [W-1:0] en_q, mask_q, kind_q, pol_q;
    logic [W-1:0] prev_act_q, ev_lat_q;
    logic [W-1:0] act, next_pol, edge_hit, eoi_clr, level_hit;
    logic         pol_wr, eoi_wr, irq_q;

    assign pol_wr   = wr_i && (sel_i == SEL_IPOL);
    assign eoi_wr   = wr_i && (sel_i == SEL_IEOI);
    assign eoi_clr  = eoi_wr ? wdata_i : '0;
    assign next_pol = pol_wr ? wdata_i : pol_q;

    // active under the current polarity: high when pin equals polarity bit
    assign act       = din_i ~^ pol_q;
    assign edge_hit  = act & ~prev_act_q & en_q & kind_q;
    assign level_hit = act & en_q & ~kind_q;
    assign status_o  = (ev_lat_q | level_hit) & ~mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q       <= '0;
            mask_q     <= '0;
            kind_q     <= '0;
            pol_q      <= '0;
            prev_act_q <= '0;
            ev_lat_q   <= '0;
            irq_q      <= 1'b0;
        end else begin
            if (wr_i && sel_i == SEL_IEN)  en_q   <= wdata_i;
            if (wr_i && sel_i == SEL_IMSK) mask_q <= wdata_i;
            if (wr_i && sel_i == SEL_ITYP) kind_q <= wdata_i;
            pol_q      <= next_pol;
            // track the active level under next cycle's polarity: no false edge
            prev_act_q <= din_i ~^ next_pol;
            ev_lat_q   <= en_q & kind_q & ((ev_lat_q & ~eoi_clr) | edge_hit);
            irq_q      <= |status_o;
        end
    end

    assign en_o   = en_q;
    assign mask_o = mask_q;
    assign kind_o = kind_q;
    assign pol_o  = pol_q;
    assign irq_o  = irq_q;

    // R6
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !eoi_wr |=> ((ev_lat_q & $past(ev_lat_q & en_q & kind_q)) == $past(ev_lat_q & en_q & kind_q)));

    // R11
    eoi_race_chk: assert property (@(posedge clk) disable iff (rst)
        (eoi_wr && ((edge_hit & eoi_clr) != '0)) |=>
            ((ev_lat_q & $past(edge_hit & eoi_clr)) == $past(edge_hit & eoi_clr)));

    // R10
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> ($past(status_o) != '0));

endmodule

// File: rtl/apb_gpio_ctrl.sv
module apb_gpio_ctrl
    import gpio_ctrl_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          psel,
    input  logic                          penable,
    input  logic                          pwrite,
    input  logic [ADDR_W-1:0]             paddr,
    input  logic [DATA_W-1:0]             pwdata,
    output logic [DATA_W-1:0]             prdata,
    output logic                          pready,
    input  logic [NUM_PORTS*PORT_W-1:0]   pad_in,
    output logic [NUM_PORTS*PORT_W-1:0]   pad_out,
    output logic [NUM_PORTS*PORT_W-1:0]   pad_oe,
    output logic                          irq
);
    localparam int PAD_W = NUM_PORTS * PORT_W;

    logic [PORT_W-1:0] out_q [NUM_PORTS];
    logic [PORT_W-1:0] dir_q [NUM_PORTS];
    logic [PORT_W-1:0] ext_w [NUM_PORTS];
    logic [PAD_W-1:0]  pad_sync;
    logic [PORT_W-1:0] wdata, rd_val;
    logic [PORT_W-1:0] ien, imsk, ityp, ipol, ista;
    logic              wr_en;
    reg_hit_t          hit;

    assign hit    = decode_addr(paddr, NUM_PORTS);
    assign wr_en  = psel && penable && pwrite;
    assign wdata  = pwdata[PORT_W-1:0];
    assign pready = 1'b1;

    gpio_sync2 #(.W(PAD_W)) i_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pad_in),
        .q_o (pad_sync)
    );

    always_ff @(posedge clk) begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (rst) begin
                out_q[p] <= '0;
                dir_q[p] <= '0;
            end else if (wr_en && hit.port == 2'(p)) begin
                if (hit.sel == SEL_OUT) out_q[p] <= wdata;
                if (hit.sel == SEL_DIR) dir_q[p] <= wdata;
            end
        end
    end

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        assign pad_out[g*PORT_W +: PORT_W] = out_q[g];
        assign pad_oe[g*PORT_W +: PORT_W]  = dir_q[g];
        assign ext_w[g]                    = pad_sync[g*PORT_W +: PORT_W];
    end

    gpio_irq_unit #(.W(PORT_W)) i_irq (
        .clk      (clk),
        .rst      (rst),
        .din_i    (pad_sync[PORT_W-1:0]),
        .wr_i     (wr_en),
        .sel_i    (hit.sel),
        .wdata_i  (wdata),
        .en_o     (ien),
        .mask_o   (imsk),
        .kind_o   (ityp),
        .pol_o    (ipol),
        .status_o (ista),
        .irq_o    (irq)
    );

    always_comb begin
        case (hit.sel)
            SEL_OUT:  rd_val = out_q[hit.port];
            SEL_DIR:  rd_val = dir_q[hit.port];
            SEL_EXT:  rd_val = ext_w[hit.port];
            SEL_IEN:  rd_val = ien;
            SEL_IMSK: rd_val = imsk;
            SEL_ITYP: rd_val = ityp;
            SEL_IPOL: rd_val = ipol;
            SEL_ISTA: rd_val = ista;
            default:  rd_val = '0;
        endcase
    end

    assign prdata = DATA_W'(rd_val);

    // R2
    dir_write_chk: assert property (@(posedge clk) disable iff (rst)
        (psel && penable && pwrite && paddr == DIR_BASE) |=>
            (pad_oe[PORT_W-1:0] == $past(pwdata[PORT_W-1:0])));

endmodule

// File: tb/test_apb_gpio_ctrl.sv
module test_apb_gpio_ctrl;
    localparam int NP = 4;
    localparam int PW = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]        paddr = '0;
    logic [31:0]       pwdata = '0;
    logic [31:0]       prdata;
    logic              pready;
    logic [NP*PW-1:0]  pad_in = '0;
    logic [NP*PW-1:0]  pad_out, pad_oe;
    logic              irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    apb_gpio_ctrl #(.NUM_PORTS(NP), .PORT_W(PW)) i_apb_gpio_ctrl (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        apb_rd(a, v);
        check(req, v, exp);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 pad_out", pad_out[31:0], 32'h0);
        check("R1 pad_oe", pad_oe[127:96], 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        rd_check("R1 out0", 8'h00, 32'h0);
        rd_check("R1 dir2", 8'h1C, 32'h0);
        rd_check("R1 ien", 8'h30, 32'h0);
        rd_check("R1 status", 8'h40, 32'h0);
    endtask

    task automatic t_ports();
        for (int n = 0; n < NP; n++) begin
            apb_wr(8'(n * 12), 32'hA5000000 + 32'(n));
            apb_wr(8'(4 + n * 12), 32'h0F0F0000 + 32'(n));
        end
        for (int n = 0; n < NP; n++) begin
            rd_check("R2 out readback", 8'(n * 12), 32'hA5000000 + 32'(n));
            rd_check("R2 dir readback", 8'(4 + n * 12), 32'h0F0F0000 + 32'(n));
            check("R2 pad_out", pad_out[n*PW +: PW], 32'hA5000000 + 32'(n));
            check("R2 pad_oe", pad_oe[n*PW +: PW], 32'h0F0F0000 + 32'(n));
        end
    endtask

    task automatic t_ext();
        pad_in[127:32] = {32'h33333333, 32'h22222222, 32'h11111111};
        settle();
        for (int n = 1; n < NP; n++)
            rd_check("R3 ext read", 8'(8'h50 + n * 4), {8{4'(n)}});
        apb_wr(8'h54, 32'hFFFFFFFF);
        rd_check("R3 ext write ignored", 8'h54, 32'h11111111);
        rd_check("R3 out1 untouched", 8'h0C, 32'hA5000001);
    endtask

    task automatic t_unmapped();
        apb_wr(8'h08, 32'hDEADBEEF);
        apb_wr(8'h44, 32'hDEADBEEF);
        rd_check("R4 read 0x08", 8'h08, 32'h0);
        rd_check("R4 read 0x44", 8'h44, 32'h0);
        rd_check("R4 read 0x60", 8'h60, 32'h0);
        rd_check("R4 out0 untouched", 8'h00, 32'hA5000000);
        rd_check("R4 dir0 untouched", 8'h04, 32'h0F0F0000);
        rd_check("R4 ien untouched", 8'h30, 32'h0);
    endtask

    task automatic t_cfg();
        apb_wr(8'h34, 32'h12345678);
        apb_wr(8'h38, 32'h9ABCDEF0);
        apb_wr(8'h3C, 32'h0F1E2D3C);
        rd_check("R12 mask rb", 8'h34, 32'h12345678);
        rd_check("R12 type rb", 8'h38, 32'h9ABCDEF0);
        rd_check("R12 pol rb", 8'h3C, 32'h0F1E2D3C);
        apb_wr(8'h40, 32'hFFFFFFFF);
        rd_check("R12 status write ignored", 8'h40, 32'h0);
        apb_wr(8'h34, 32'h0);
        apb_wr(8'h38, 32'h0);
        apb_wr(8'h3C, 32'h0);
    endtask

    task automatic t_level();
        pad_in[31:0] = 32'h0;
        apb_wr(8'h3C, 32'h1);   // pin0 active high, pin1 active low
        apb_wr(8'h30, 32'h3);
        settle();
        rd_check("R5 level low-active", 8'h40, 32'h2);
        check("R10 irq on level", {31'b0, irq}, 32'h1);
        pad_in[0] = 1'b1;
        settle();
        rd_check("R5 level both", 8'h40, 32'h3);
        apb_wr(8'h4C, 32'h3);
        rd_check("R5 eoi no effect on level", 8'h40, 32'h3);
        pad_in[1] = 1'b1;
        settle();
        rd_check("R5 level follows input", 8'h40, 32'h1);
        pad_in[0] = 1'b0;
        settle();
        rd_check("R5 level not latched", 8'h40, 32'h0);
        check("R10 irq drops", {31'b0, irq}, 32'h0);
        pad_in[1] = 1'b0;
        apb_wr(8'h30, 32'h1);   // pin1 disabled, would be active
        settle();
        rd_check("R8 disabled level pin", 8'h40, 32'h0);
        apb_wr(8'h30, 32'h0);
        apb_wr(8'h3C, 32'h0);
    endtask

    task automatic t_edge();
        pad_in[31:0] = 32'hC0;
        apb_wr(8'h38, 32'hF0);
        apb_wr(8'h3C, 32'h30);  // 4,5 rising; 6,7 falling
        apb_wr(8'h30, 32'hF0);
        settle();
        rd_check("R6 no event idle", 8'h40, 32'h0);
        pad_in[31:0] = 32'hB8;  // 4,5 rise, 6 falls, pin3 toggles (disabled)
        settle();
        rd_check("R6 edges latched", 8'h40, 32'h70);
        rd_check("R8 disabled edge pin", 8'h40, 32'h70);
        pad_in[31:0] = 32'hC0;
        settle();
        rd_check("R6 latch holds", 8'h40, 32'h70);
        apb_wr(8'h4C, 32'h10);
        rd_check("R6 eoi one bit", 8'h40, 32'h60);
        apb_wr(8'h4C, 32'h20);
        rd_check("R6 zero bits unaffected", 8'h40, 32'h40);
        apb_wr(8'h4C, 32'h40);
        rd_check("R6 all cleared", 8'h40, 32'h0);
        check("R10 irq clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_mask();
        apb_wr(8'h34, 32'h10);
        pad_in[31:0] = 32'hD0;
        settle();
        rd_check("R7 masked status", 8'h40, 32'h0);
        check("R7 masked irq", {31'b0, irq}, 32'h0);
        apb_wr(8'h34, 32'h0);
        rd_check("R7 unmask reveals", 8'h40, 32'h10);
        check("R7 irq after unmask", {31'b0, irq}, 32'h1);
        apb_wr(8'h4C, 32'h10);
        rd_check("R7 cleared", 8'h40, 32'h0);
    endtask

    task automatic t_pol();
        // pin4 held high; flip its polarity twice
        apb_wr(8'h3C, 32'h20);
        settle();
        rd_check("R9 pol to falling", 8'h40, 32'h0);
        apb_wr(8'h3C, 32'h30);
        settle();
        rd_check("R9 pol back to rising", 8'h40, 32'h0);
        pad_in[4] = 1'b0;
        settle();
    endtask

    task automatic t_irq_timing();
        @(negedge clk);
        pad_in[4] = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 irq not yet", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R10 irq one cycle after status", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_race();
        // pin4 already latched; pin5 edge meets EOI of pins 4 and 5
        @(negedge clk);
        pad_in[5] = 1'b1;
        @(posedge clk);
        apb_wr(8'h4C, 32'h30);
        rd_check("R11 new event survives eoi", 8'h40, 32'h20);
        apb_wr(8'h4C, 32'h20);
        rd_check("R11 later eoi clears", 8'h40, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ports();
        t_ext();
        t_unmapped();
        t_cfg();
        t_level();
        t_edge();
        t_mask();
        t_pol();
        t_irq_timing();
        t_race();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule